// File: doc/BRIEF.md
# Saturating Integer Divider

This block is a multi-cycle integer divider for a processor execution pipeline. A one-cycle start strobe launches a division. The strobe carries a dividend, a divisor and a mode select, which picks signed (two's complement) or unsigned operands. When the division completes, the block raises a one-cycle done strobe and presents a packed result of width 2·W. The quotient sits in bits W-1:0 and the remainder in bits 2W-1:W. The result holds until the next division completes.

A zero divisor, and a signed divide of the most negative value by minus one, never trap. The block detects these cases in its first working cycle and returns a defined saturated quotient with a zero remainder. All other operands go through a restoring shift-subtract core on operand magnitudes. The core takes one cycle per quotient bit. A final cycle restores the signs.

Three status flags travel with the result:
- **overflow** marks a saturated outcome.
- **sticky overflow** accumulates overflow.
- **advanced overflow** is cleared by every divide.

The control FSM has four states:
- **IDLE**: waits for start, which moves it to CHECK.
- **CHECK**: moves to IDLE with the saturated result when a special case is hit, and otherwise loads the core and moves to ITER.
- **ITER**: runs W core steps, then moves to FIXUP.
- **FIXUP**: applies signs, writes the result and returns to IDLE.

Top module: `sat_divider`

## Requirements
- R1: In unsigned mode with a nonzero divisor, result[W-1:0] is the truncated quotient and result[2W-1:W] is the remainder.
- R2: In signed mode, the quotient truncates toward zero and the remainder carries the sign of the dividend (for example, -7 / 2 gives -3 remainder -1).
- R3: In signed mode with a zero divisor, the quotient is 0x7FFFFFFF when the dividend is non-negative and 0x80000000 when it is negative, and the remainder is 0.
- R4: In signed mode, a dividend of 0x80000000 divided by 0xFFFFFFFF gives quotient 0x7FFFFFFF and remainder 0. Other operands involving 0x80000000 divide normally.
- R5: In unsigned mode with a zero divisor, the quotient is 0xFFFFFFFF and the remainder is 0.
- R6: The overflow flag is 1 after every case of R3, R4 and R5, and 0 after any other division.
- R7: The sticky overflow flag becomes the OR of its old value and the new overflow value, and only reset clears it.
- R8: The advanced overflow flag is 0 after every division.
- R9: Counting the clock edge that accepts start as edge 0, done is high after edge 1 for a special case and after edge W+2 for a normal division.
- R10: A start strobe while busy is high is ignored. The running division finishes with its own operands and timing, and no extra done pulse follows.
- R11: Done is high for exactly one cycle per division, and the result and flags stay unchanged until the next division completes.
- R12: After reset, busy, done, result and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| signed_i | input | 1 | 1 selects signed operands, 0 selects unsigned |
| dividend_i | input | W | Dividend |
| divisor_i | input | W | Divisor |
| busy_o | output | 1 | High while a division is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 2W | Remainder in the upper half, quotient in the lower half |
| ovf_o | output | 1 | Overflow flag of the last division |
| sticky_ovf_o | output | 1 | Accumulated overflow |
| adv_ovf_o | output | 1 | Advanced overflow flag, cleared by divides |

## Verification
The bench builds the divider with its default W of 32. This width makes the saturation constants 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF exact, and it makes the normal latency 34 edges, both of which the bench checks directly. At this width, the most-negative dividend can be combined with divisors of -1, 1 and 0, and the same bit pattern can be divided in unsigned mode. This shows that mode select alone separates saturation from normal division. A second start pulse placed in the middle of the 32 iteration cycles tests that the block ignores starts while busy.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ITER,
        ST_FIXUP
    } div_state_t;

endpackage

// File: rtl/sdiv_special.sv
module sdiv_special #(
    parameter int W = 32
) (
    input  logic         signed_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         hit_o,
    output logic [W-1:0] quo_o
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL_ONE = {W{1'b1}};

    logic zero_div;
    logic min_by_m1;

    always_comb begin
        zero_div  = (b_i == '0);
        min_by_m1 = signed_i && (a_i == MIN_NEG) && (b_i == ALL_ONE);
        hit_o     = zero_div || min_by_m1;
        quo_o     = '0;
        if (zero_div) begin
            if (!signed_i)
                quo_o = ALL_ONE;
            else if (a_i[W-1])
                quo_o = MIN_NEG;
            else
                quo_o = MAX_POS;
        end else if (min_by_m1) begin
            quo_o = MAX_POS;
        end
    end

endmodule

// File: rtl/sdiv_iter.sv
module sdiv_iter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] dvs_q;
    logic [W:0]   shifted;
    logic [W:0]   trial;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, dvs_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (load_i) begin
            rem_q <= '0;
            quo_q <= dvd_i;
            dvs_q <= dvs_i;
        end else if (step_i) begin
            if (!trial[W]) begin
                rem_q <= trial[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
                rem_q <= shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b0};
            end
        end
    end

    assign quo_o = quo_q;
    assign rem_o = rem_q;

    // partial remainder always stays below the divisor (R1)
    assert_rem_below_divisor_R1: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (rem_q < dvs_q));

endmodule

// File: rtl/sat_divider.sv
module sat_divider
    import sdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           signed_i,
    input  logic [W-1:0]   dividend_i,
    input  logic [W-1:0]   divisor_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*W-1:0] result_o,
    output logic           ovf_o,
    output logic           sticky_ovf_o,
    output logic           adv_ovf_o
);
    localparam int            CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_t    state_q, state_d;
    logic [W-1:0]  a_q, b_q;
    logic          sgn_q;
    logic [CW-1:0] cnt_q;

    logic          spec_hit;
    logic [W-1:0]  spec_quo;
    logic          a_neg, b_neg;
    logic [W-1:0]  a_mag, b_mag;
    logic [W-1:0]  core_quo, core_rem;
    logic [W-1:0]  fix_quo, fix_rem;
    logic          accept;

    assign accept = (state_q == ST_IDLE) && start_i;
    assign busy_o = (state_q != ST_IDLE);

    sdiv_special #(.W(W)) u_special (
        .signed_i (sgn_q),
        .a_i      (a_q),
        .b_i      (b_q),
        .hit_o    (spec_hit),
        .quo_o    (spec_quo)
    );

    always_comb begin
        a_neg   = sgn_q && a_q[W-1];
        b_neg   = sgn_q && b_q[W-1];
        a_mag   = a_neg ? (~a_q + 1'b1) : a_q;
        b_mag   = b_neg ? (~b_q + 1'b1) : b_q;
        fix_quo = (a_neg ^ b_neg) ? (~core_quo + 1'b1) : core_quo;
        fix_rem = a_neg ? (~core_rem + 1'b1) : core_rem;
    end

    sdiv_iter #(.W(W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i ((state_q == ST_CHECK) && !spec_hit),
        .step_i (state_q == ST_ITER),
        .dvd_i  (a_mag),
        .dvs_i  (b_mag),
        .quo_o  (core_quo),
        .rem_o  (core_rem)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_CHECK;
            ST_CHECK: state_d = spec_hit ? ST_IDLE : ST_ITER;
            ST_ITER:  if (cnt_q == LAST) state_d = ST_FIXUP;
            ST_FIXUP: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand capture and iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            sgn_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            if (accept) begin
                a_q   <= dividend_i;
                b_q   <= divisor_i;
                sgn_q <= signed_i;
            end
            if (state_q == ST_ITER) cnt_q <= cnt_q + 1'b1;
            else                    cnt_q <= '0;
        end
    end

    // outputs: result, strobe and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o     <= '0;
            done_o       <= 1'b0;
            ovf_o        <= 1'b0;
            sticky_ovf_o <= 1'b0;
            adv_ovf_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_CHECK: begin
                    if (spec_hit) begin
                        result_o     <= {{W{1'b0}}, spec_quo};
                        done_o       <= 1'b1;
                        ovf_o        <= 1'b1;
                        sticky_ovf_o <= 1'b1;
                        adv_ovf_o    <= 1'b0;
                    end
                end
                ST_FIXUP: begin
                    result_o     <= {fix_rem, fix_quo};
                    done_o       <= 1'b1;
                    ovf_o        <= 1'b0;
                    sticky_ovf_o <= sticky_ovf_o;
                    adv_ovf_o    <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_result_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(ovf_o)));

    assert_sticky_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_ovf_o |=> sticky_ovf_o);

    assert_adv_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !adv_ovf_o);

    assert_sat_rem_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovf_o) |-> (result_o[2*W-1:W] == '0));

    assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(a_q) && $stable(b_q) && $stable(sgn_q)));

    assert_special_early_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CHECK) && spec_hit) |=> (done_o && !busy_o));

endmodule

// File: tb/sat_divider_bench.sv
`timescale 1ns/1ps
module sat_divider_bench;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          signed_i = 1'b0;
    logic [W-1:0]  dividend_i = '0;
    logic [W-1:0]  divisor_i = '0;
    logic          busy_o, done_o, ovf_o, sticky_ovf_o, adv_ovf_o;
    logic [2*W-1:0] result_o;

    int checks = 0;
    int fails  = 0;
    logic sticky_exp = 1'b0;

    always #2 clk = ~clk;

    sat_divider #(.W(W)) u_sat_divider (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i), .busy_o(busy_o),
        .done_o(done_o), .result_o(result_o), .ovf_o(ovf_o),
        .sticky_ovf_o(sticky_ovf_o), .adv_ovf_o(adv_ovf_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model(input logic sg, input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [W-1:0] q, output logic [W-1:0] r, output logic ov);
        if (b == 0) begin
            ov = 1'b1; r = '0;
            if (!sg)       q = 32'hFFFF_FFFF;
            else if (a[31]) q = 32'h8000_0000;
            else           q = 32'h7FFF_FFFF;
        end else if (sg && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
            ov = 1'b1; q = 32'h7FFF_FFFF; r = '0;
        end else if (sg) begin
            ov = 1'b0;
            q = $signed(a) / $signed(b);
            r = $signed(a) % $signed(b);
        end else begin
            ov = 1'b0; q = a / b; r = a % b;
        end
    endtask

    task automatic pulse_start(input logic sg, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        start_i = 1'b1; signed_i = sg; dividend_i = a; divisor_i = b;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done_o && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_div(input string req, input logic sg,
                           input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] q, r;
        logic ov;
        int lat;
        model(sg, a, b, q, r, ov);
        sticky_exp = sticky_exp | ov;
        pulse_start(sg, a, b);
        wait_done(lat);
        chk({req, " result"}, result_o, {r, q});
        chk("R6 overflow", {63'd0, ovf_o}, {63'd0, ov});
        chk("R7 sticky", {63'd0, sticky_ovf_o}, {63'd0, sticky_exp});
        chk("R8 advanced", {63'd0, adv_ovf_o}, 64'd0);
        chk("R9 latency", lat, ov ? 1 : W + 2);
        @(negedge clk);
        chk("R11 done width", {63'd0, done_o}, 64'd0);
    endtask

    task automatic t_reset;
        chk("R12 busy", {63'd0, busy_o}, 64'd0);
        chk("R12 done", {63'd0, done_o}, 64'd0);
        chk("R12 result", result_o, 64'd0);
        chk("R12 flags", {61'd0, ovf_o, sticky_ovf_o, adv_ovf_o}, 64'd0);
    endtask

    task automatic t_busy_ignore;
        logic [W-1:0] q, r;
        logic ov;
        int lat;
        model(1'b0, 32'd1000, 32'd7, q, r, ov);
        pulse_start(1'b0, 32'd1000, 32'd7);
        repeat (5) @(negedge clk);
        start_i = 1'b1; dividend_i = 32'd5; divisor_i = 32'd0;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(lat);
        chk("R10 busy start ignored result", result_o, {r, q});
        chk("R10 busy latency", lat + 6, W + 2);
        chk("R10 no saturation", {63'd0, ovf_o}, 64'd0);
        repeat (40) begin
            @(negedge clk);
            if (done_o) chk("R10 extra done", 64'd1, 64'd0);
        end
        chk("R11 result held", result_o, {r, q});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        run_div("R1 unsigned", 1'b0, 32'd100, 32'd7);
        run_div("R1 unsigned big", 1'b0, 32'hFFFF_FFFF, 32'd16);
        run_div("R1 unsigned top bit", 1'b0, 32'h8000_0000, 32'hFFFF_FFFF);
        run_div("R2 neg by pos", 1'b1, -32'sd7, 32'sd2);
        run_div("R2 pos by neg", 1'b1, 32'sd7, -32'sd2);
        run_div("R2 neg by neg", 1'b1, -32'sd7, -32'sd2);
        run_div("R4 min by one", 1'b1, 32'h8000_0000, 32'd1);
        run_div("R3 pos by zero", 1'b1, 32'd42, 32'd0);
        run_div("R2 normal after sat", 1'b1, 32'd9, 32'd3);
        run_div("R3 neg by zero", 1'b1, 32'hFFFF_FFF0, 32'd0);
        run_div("R3 zero by zero", 1'b1, 32'd0, 32'd0);
        run_div("R4 min by minus one", 1'b1, 32'h8000_0000, 32'hFFFF_FFFF);
        run_div("R5 unsigned by zero", 1'b0, 32'h8000_0000, 32'd0);
        run_div("R1 unsigned smaller", 1'b0, 32'd3, 32'd10);
        t_busy_ignore();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #100000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule